// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the control and status registers of a multi-channel DMA layer that feeds a network interface. Software reaches it through a simple register bus. A 10-bit register number selects the register, and separate read and write strobes carry the access. A write takes effect at the next clock edge. Read data is captured in a register and appears one cycle after the read strobe.

The block has fixed registers: a configuration word, an error status word, an interrupt enable mask, channel-activate and channel-deactivate words for each direction, and four interrupt status words. It also has three arrays whose length is set by parameters: transmit descriptor pointers, receive descriptor pointers and receive buffer sizes. Hardware raises status bits through pulse inputs, and software clears them by writing ones. Setting bit 31 of a configuration write returns the control and status state to its reset values, while the configuration word takes the written value.

The descriptor engine, the data movers and the interrupt logic are separate blocks outside this one.

Top module: `dmachan_regfile`

## Requirements
- R1: After reset, the configuration register (0x180) reads 0x0007C000. The error status (0x181), interrupt enable (0x182), tx activate (0x184), tx deactivate (0x185), tx end-of-buffer status (0x186), tx descriptor-error status (0x187), rx activate (0x190), rx deactivate (0x191), rx end-of-buffer status (0x192) and rx descriptor-error status (0x193) all read zero.
- R2: Each fixed register answers only at its own register number listed in R1.
- R3: Writes are masked as follows: configuration keeps the bits of 0x00FFC087, interrupt enable keeps bits 4:0, tx activate and tx deactivate keep bits 31:28, and rx activate and rx deactivate keep bits 31:30.
- R4: The five status registers (0x181, 0x186, 0x187, 0x192, 0x193) clear every bit written as 1 and keep every bit written as 0.
- R5: A pulse on a bit of a status register's set input makes that bit 1 on the next edge. When a set and a clear reach the same bit in the same cycle, the set wins.
- R6: A write to 0x180 with bit 31 set clears interrupt enable, the four activate/deactivate words and the five status words. The configuration register then takes the written value masked by 0x00FFC087.
- R7: Transmit pointer n sits at 0x1A0+n and receive pointer n at 0x1C0+n. Both store all 32 bits, and each exists only for n below its channel count.
- R8: Receive buffer size n sits at 0x1E0+n, keeps bits 7:0 of a write, and exists only for n below the receive channel count.
- R9: Neither the hardware reset nor the configuration-triggered reset changes the pointers or the buffer sizes.
- R10: A read of any register number that is not implemented returns zero. A write to one changes no register.
- R11: Read data reflects the addressed register on the cycle after the read strobe, and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcr_sel | input | 10 | Register number |
| dcr_wr | input | 1 | Write strobe |
| dcr_rd | input | 1 | Read strobe |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Registered read data |
| err_set | input | 32 | Set pulses for error status |
| tx_eob_set | input | 32 | Set pulses for tx end-of-buffer status |
| tx_derr_set | input | 32 | Set pulses for tx descriptor-error status |
| rx_eob_set | input | 32 | Set pulses for rx end-of-buffer status |
| rx_derr_set | input | 32 | Set pulses for rx descriptor-error status |

## Verification
The assertions assume that read and write strobes are never raised together, so read data always reflects the state before any write. They also assume that each access carries a single register number for one cycle. The bench meets these assumptions by issuing every access from a task that raises exactly one strobe for exactly one cycle. Set pulses are driven between edges, and a set pulse is combined with a write only in the cases meant to test set-over-clear priority.

// File: rtl/dcrf_pkg.sv
package dcrf_pkg;
  localparam logic [9:0] A_CFG    = 10'h180;
  localparam logic [9:0] A_ERR    = 10'h181;
  localparam logic [9:0] A_IEN    = 10'h182;
  localparam logic [9:0] A_TXON   = 10'h184;
  localparam logic [9:0] A_TXOFF  = 10'h185;
  localparam logic [9:0] A_TXEOB  = 10'h186;
  localparam logic [9:0] A_TXDERR = 10'h187;
  localparam logic [9:0] A_RXON   = 10'h190;
  localparam logic [9:0] A_RXOFF  = 10'h191;
  localparam logic [9:0] A_RXEOB  = 10'h192;
  localparam logic [9:0] A_RXDERR = 10'h193;
  localparam logic [9:0] A_TXPTR  = 10'h1A0;
  localparam logic [9:0] A_RXPTR  = 10'h1C0;
  localparam logic [9:0] A_RXBSZ  = 10'h1E0;

  localparam logic [31:0] CFG_RESET  = 32'h0007_C000;
  localparam logic [31:0] CFG_KEEP   = 32'h00FF_C087;
  localparam logic [31:0] IEN_KEEP   = 32'h0000_001F;
  localparam logic [31:0] TXACT_KEEP = 32'hF000_0000;
  localparam logic [31:0] RXACT_KEEP = 32'hC000_0000;
  localparam logic [31:0] BSZ_KEEP   = 32'h0000_00FF;
  localparam logic [31:0] PTR_KEEP   = 32'hFFFF_FFFF;

  localparam int NSTAT = 5;

  // register number of status word i (error, tx eob, tx derr, rx eob, rx derr)
  function automatic logic [9:0] stat_addr(input int i);
    case (i)
      0:       return A_ERR;
      1:       return A_TXEOB;
      2:       return A_TXDERR;
      3:       return A_RXEOB;
      default: return A_RXDERR;
    endcase
  endfunction

  function automatic logic in_window(input logic [9:0] sel, input logic [9:0] base,
                                     input int count);
    return (int'(sel) >= int'(base)) && (int'(sel) < int'(base) + count);
  endfunction

  // hardware set has priority over software clear
  function automatic logic [31:0] w1c_next(input logic [31:0] q, input logic [31:0] clr,
                                           input logic [31:0] set);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/dcrf_w1c.sv
module dcrf_w1c import dcrf_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        clr_wr,
  input  logic [31:0] wdata,
  input  logic [31:0] set,
  output logic [31:0] q
);
  logic [31:0] clr_mask;

  always_comb begin
    if (soft_rst)    clr_mask = '1;
    else if (clr_wr) clr_mask = wdata;
    else             clr_mask = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, clr_mask, set);
  end
endmodule

// File: rtl/dcrf_chan_bank.sv
module dcrf_chan_bank import dcrf_pkg::*; #(
  parameter int          N    = 4,
  parameter logic [9:0]  BASE = 10'h1A0,
  parameter logic [31:0] KEEP = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic [9:0]  sel,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        hit,
  output logic [31:0] rdata
);
  logic [31:0] mem [N];
  logic [9:0]  off;

  assign hit = in_window(sel, BASE, N);
  assign off = sel - BASE;

  // contents deliberately untouched by any reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (wr_en && hit && off == 10'(i)) mem[i] <= wdata & KEEP;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (hit && off == 10'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/dmachan_regfile.sv
module dmachan_regfile import dcrf_pkg::*; #(
  parameter int TX_CHANS = 4,
  parameter int RX_CHANS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  dcr_sel,
  input  logic        dcr_wr,
  input  logic        dcr_rd,
  input  logic [31:0] dcr_wdata,
  output logic [31:0] dcr_rdata,
  input  logic [31:0] err_set,
  input  logic [31:0] tx_eob_set,
  input  logic [31:0] tx_derr_set,
  input  logic [31:0] rx_eob_set,
  input  logic [31:0] rx_derr_set
);
  logic [31:0] cfg_q, ier_q, txon_q, txoff_q, rxon_q, rxoff_q;
  logic [31:0] stat_q   [NSTAT];
  logic [31:0] stat_set [NSTAT];
  logic        wr_cfg, soft_rst;
  logic        txptr_hit, rxptr_hit, bsz_hit;
  logic [31:0] txptr_rd, rxptr_rd, bsz_rd, rd_next;
  logic [31:0] esr_q, txeob_q;

  assign stat_set[0] = err_set;
  assign stat_set[1] = tx_eob_set;
  assign stat_set[2] = tx_derr_set;
  assign stat_set[3] = rx_eob_set;
  assign stat_set[4] = rx_derr_set;

  assign wr_cfg   = dcr_wr && (dcr_sel == A_CFG);
  assign soft_rst = wr_cfg && dcr_wdata[31];
  assign esr_q    = stat_q[0];
  assign txeob_q  = stat_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      ier_q   <= '0;
      txon_q  <= '0;
      txoff_q <= '0;
      rxon_q  <= '0;
      rxoff_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= dcr_wdata & CFG_KEEP;
      if (soft_rst) begin
        ier_q   <= '0;
        txon_q  <= '0;
        txoff_q <= '0;
        rxon_q  <= '0;
        rxoff_q <= '0;
      end else if (dcr_wr) begin
        case (dcr_sel)
          A_IEN:   ier_q   <= dcr_wdata & IEN_KEEP;
          A_TXON:  txon_q  <= dcr_wdata & TXACT_KEEP;
          A_TXOFF: txoff_q <= dcr_wdata & TXACT_KEEP;
          A_RXON:  rxon_q  <= dcr_wdata & RXACT_KEEP;
          A_RXOFF: rxoff_q <= dcr_wdata & RXACT_KEEP;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    dcrf_w1c u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .clr_wr  (dcr_wr && (dcr_sel == stat_addr(g))),
      .wdata   (dcr_wdata),
      .set     (stat_set[g]),
      .q       (stat_q[g])
    );
  end

  dcrf_chan_bank #(.N(TX_CHANS), .BASE(A_TXPTR), .KEEP(PTR_KEEP)) u_txptr (
    .clk(clk), .sel(dcr_sel), .wr_en(dcr_wr), .wdata(dcr_wdata),
    .hit(txptr_hit), .rdata(txptr_rd));

  dcrf_chan_bank #(.N(RX_CHANS), .BASE(A_RXPTR), .KEEP(PTR_KEEP)) u_rxptr (
    .clk(clk), .sel(dcr_sel), .wr_en(dcr_wr), .wdata(dcr_wdata),
    .hit(rxptr_hit), .rdata(rxptr_rd));

  dcrf_chan_bank #(.N(RX_CHANS), .BASE(A_RXBSZ), .KEEP(BSZ_KEEP)) u_bsz (
    .clk(clk), .sel(dcr_sel), .wr_en(dcr_wr), .wdata(dcr_wdata),
    .hit(bsz_hit), .rdata(bsz_rd));

  always_comb begin
    case (dcr_sel)
      A_CFG:    rd_next = cfg_q;
      A_ERR:    rd_next = stat_q[0];
      A_IEN:    rd_next = ier_q;
      A_TXON:   rd_next = txon_q;
      A_TXOFF:  rd_next = txoff_q;
      A_TXEOB:  rd_next = stat_q[1];
      A_TXDERR: rd_next = stat_q[2];
      A_RXON:   rd_next = rxon_q;
      A_RXOFF:  rd_next = rxoff_q;
      A_RXEOB:  rd_next = stat_q[3];
      A_RXDERR: rd_next = stat_q[4];
      default:  rd_next = '0;
    endcase
    if (txptr_hit) rd_next = txptr_rd;
    if (rxptr_hit) rd_next = rxptr_rd;
    if (bsz_hit)   rd_next = bsz_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dcr_rdata <= '0;
    else if (dcr_rd) dcr_rdata <= rd_next;
  end
endmodule

// File: rtl/dcrf_chk.sv
module dcrf_chk import dcrf_pkg::*; (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  dcr_sel,
  input logic        dcr_wr,
  input logic        dcr_rd,
  input logic [31:0] dcr_wdata,
  input logic [31:0] dcr_rdata,
  input logic [31:0] err_set,
  input logic [31:0] tx_eob_set,
  input logic [31:0] esr_q,
  input logic [31:0] txeob_q,
  input logic [31:0] ier_q,
  input logic [31:0] txon_q,
  input logic [31:0] cfg_q,
  input logic        soft_rst
);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_eob_set != 32'h0) |=> ((txeob_q & $past(tx_eob_set)) == $past(tx_eob_set)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_wr && dcr_sel == A_ERR && err_set == 32'h0)
      |=> (esr_q == ($past(esr_q) & ~$past(dcr_wdata))));

  // R6
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ier_q == 32'h0 && txon_q == 32'h0 &&
                  cfg_q == ($past(dcr_wdata) & CFG_KEEP)));

  // R10
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcr_rd && dcr_sel == 10'h183) |=> (dcr_rdata == 32'h0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dcr_rd |=> $stable(dcr_rdata));
endmodule

bind dmachan_regfile dcrf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dcr_sel(dcr_sel), .dcr_wr(dcr_wr), .dcr_rd(dcr_rd),
  .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .err_set(err_set),
  .tx_eob_set(tx_eob_set), .esr_q(esr_q), .txeob_q(txeob_q), .ier_q(ier_q),
  .txon_q(txon_q), .cfg_q(cfg_q), .soft_rst(soft_rst));

// File: tb/dmachan_regfile_tb_top.sv
`timescale 1ns/1ps
module dmachan_regfile_tb_top;
  localparam int TXN = 4;
  localparam int RXN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  dcr_sel = '0;
  logic        dcr_wr = 1'b0, dcr_rd = 1'b0;
  logic [31:0] dcr_wdata = '0;
  logic [31:0] dcr_rdata;
  logic [31:0] err_set = '0, tx_eob_set = '0, tx_derr_set = '0, rx_eob_set = '0, rx_derr_set = '0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dmachan_regfile #(.TX_CHANS(TXN), .RX_CHANS(RXN)) dut_i (
    .clk(clk), .rst_n(rst_n), .dcr_sel(dcr_sel), .dcr_wr(dcr_wr), .dcr_rd(dcr_rd),
    .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .err_set(err_set),
    .tx_eob_set(tx_eob_set), .tx_derr_set(tx_derr_set), .rx_eob_set(rx_eob_set),
    .rx_derr_set(rx_derr_set));

  function automatic bit is_stat(int a);
    return a == 'h181 || a == 'h186 || a == 'h187 || a == 'h192 || a == 'h193;
  endfunction

  // write mask of a plain read/write register, zero when not one
  function automatic logic [31:0] wmask(int a);
    if (a == 'h180) return 32'h00FFC087;
    if (a == 'h182) return 32'h1F;
    if (a == 'h184 || a == 'h185) return 32'hF0000000;
    if (a == 'h190 || a == 'h191) return 32'hC0000000;
    if (a >= 'h1A0 && a < 'h1A0 + TXN) return 32'hFFFFFFFF;
    if (a >= 'h1C0 && a < 'h1C0 + RXN) return 32'hFFFFFFFF;
    if (a >= 'h1E0 && a < 'h1E0 + RXN) return 32'hFF;
    return 32'h0;
  endfunction

  function automatic bit is_impl(int a);
    return is_stat(a) || wmask(a) != 32'h0;
  endfunction

  function automatic logic [31:0] sig(int a);
    return (32'h9E3779B9 * 32'(a)) & 32'h7FFFFFFF;
  endfunction

  function automatic bit is_chan(int a);
    return a >= 'h1A0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] v);
    @(negedge clk);
    dcr_sel = 10'(a); dcr_wdata = v; dcr_wr = 1'b1;
    @(negedge clk);
    dcr_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    dcr_sel = 10'(a); dcr_rd = 1'b1;
    @(negedge clk);
    dcr_rd = 1'b0;
    v = dcr_rdata;
  endtask

  task automatic pulse_set(logic [31:0] e, logic [31:0] t);
    @(negedge clk);
    err_set = e; tx_eob_set = t; rx_derr_set = t;
    @(negedge clk);
    err_set = '0; tx_eob_set = '0; rx_derr_set = '0;
  endtask

  task automatic wr_with_set(int a, logic [31:0] v, logic [31:0] e);
    @(negedge clk);
    dcr_sel = 10'(a); dcr_wdata = v; dcr_wr = 1'b1; err_set = e;
    @(negedge clk);
    dcr_wr = 1'b0; err_set = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", dcr_rdata, 32'h0);

    // R1 R2: reset values at every fixed register number
    for (int a = 'h180; a < 'h1A0; a++) begin
      if (is_impl(a)) begin
        rd(a, v);
        check("R1 R2 reset value", v, (a == 'h180) ? 32'h0007C000 : 32'h0);
      end
    end

    // R3 R7 R8: mask sweep with several patterns
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'h7FFFFFFF : (p == 1) ? 32'h5A5AA5A5 : 32'h2C3D4E5F;
      for (int a = 'h180; a < 'h200; a++) begin
        if (wmask(a) != 32'h0) begin
          wr(a, pat ^ (is_chan(a) ? 32'(a) : 32'h0));
          rd(a, v);
          check(is_chan(a) ? "R7 R8 channel word" : "R3 masked write", v,
                (pat ^ (is_chan(a) ? 32'(a) : 32'h0)) & wmask(a));
        end
      end
    end

    // signature in every writable register
    for (int a = 'h180; a < 'h200; a++)
      if (wmask(a) != 32'h0) wr(a, sig(a));

    // R10: sweep of all unimplemented numbers
    for (int a = 0; a < 1024; a++) begin
      if (!is_impl(a)) begin
        wr(a, 32'hFFFFFFFF);
        rd(a, v);
        check("R10 unimplemented read", v, 32'h0);
      end
    end
    for (int a = 'h180; a < 'h200; a++) begin
      if (wmask(a) != 32'h0) begin
        rd(a, v);
        check("R10 no side effect", v, sig(a) & wmask(a));
      end
    end
    for (int a = 'h180; a < 'h1A0; a++) begin
      if (is_stat(a)) begin
        rd(a, v);
        check("R10 status untouched", v, 32'h0);
      end
    end

    // R5 R4: set, partial clear, set-over-clear
    pulse_set(32'h80000011, 32'hF0000000);
    rd('h181, v); check("R5 error set", v, 32'h80000011);
    rd('h186, v); check("R5 tx eob set", v, 32'hF0000000);
    rd('h193, v); check("R5 rx derr set", v, 32'hF0000000);
    wr('h181, 32'h00000001);
    rd('h181, v); check("R4 partial clear", v, 32'h80000010);
    wr('h186, 32'h30000000);
    rd('h186, v); check("R4 tx eob clear", v, 32'hC0000000);
    wr_with_set('h181, 32'h80000010, 32'h00000010);
    rd('h181, v); check("R5 set wins over clear", v, 32'h00000010);
    wr('h181, 32'hFFFFFFFF);
    rd('h181, v); check("R4 full clear", v, 32'h0);

    // R11: read data holds without a strobe
    rd('h182, held);
    wr('h182, 32'h00000003);
    @(negedge clk);
    check("R11 hold", dcr_rdata, held);
    rd('h182, v); check("R11 fresh read", v, 32'h3);

    // R6 R9: software reset through bit 31
    wr('h182, 32'h1F); wr('h184, 32'hF0000000); wr('h191, 32'hC0000000);
    pulse_set(32'hFFFFFFFF, 32'hFFFFFFFF);
    wr('h180, 32'h80FFFFFF);
    rd('h180, v); check("R6 cfg after soft reset", v, 32'h00FFC087);
    for (int a = 'h181; a < 'h1A0; a++) begin
      if (is_impl(a)) begin
        rd(a, v);
        check("R6 cleared by soft reset", v, 32'h0);
      end
    end
    for (int a = 'h1A0; a < 'h200; a++) begin
      if (wmask(a) != 32'h0) begin
        rd(a, v);
        check("R9 kept over soft reset", v, sig(a) & wmask(a));
      end
    end

    // R9 R1: hardware reset leaves channel words alone
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd('h180, v); check("R1 cfg after second reset", v, 32'h0007C000);
    for (int a = 'h1A0; a < 'h200; a++) begin
      if (wmask(a) != 32'h0) begin
        rd(a, v);
        check("R9 kept over hard reset", v, sig(a) & wmask(a));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule